// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block holds two identical 32-bit up-counting interval timers behind a small synchronous register port. Each timer has four word registers: a control/status word, a live count, a reload (next-interval) value and an interrupt vector. The live count advances by one on each clock in which the timer is running and the shared tick-enable input is high. When the count wraps past all ones, the timer records the event in its status flags. Depending on its control bits, it can then reload itself and keep counting, halt, or raise an interrupt request.

Software drives each timer through its control word. Three bits hold their value: run, stop-on-wrap and interrupt enable. Two bits are commands and are not stored: transfer, which copies the reload value into the count, and single step, which advances the count by one. Two status flags, done and error, are cleared by writing one to them. Each timer drives its own interrupt request line. Each timer also drives its vector register at all times, so an interrupt acknowledge cycle can take the vector straight from that output.

Top module: `dual_ivl_timer`

## Requirements
- R1: After reset, every register of both timers reads zero and both interrupt requests are low.
- R2: Control word bit 0 (run), bit 2 (stop-on-wrap) and bit 6 (interrupt enable) read back as last written. Every other bit reads zero, except bits 7 and 31. This includes bit 4 (transfer) and bit 5 (single step), which are never stored.
- R3: Control bit 7 (done) and bit 31 (error) are write-one-to-clear. Writing 1 clears the flag and writing 0 leaves it as it was.
- R4: A control write with bit 4 set copies the reload register into the count register.
- R5: A control write with bit 5 set and bit 0 written as 0 advances the count by exactly one. If that step wraps the count to zero, the count takes the reload value in the same write, and the wrap counts as an overflow under R7.
- R6: The count advances by one per clock only while run is set and tick_en is high. A register write to a timer takes precedence over its tick in that cycle.
- R7: On overflow the count becomes zero. Error is set if done was already set; otherwise done is set.
- R8: On overflow, stop-on-wrap clears run and the count stays at zero. If run is still set, the count reloads from the reload register and counting continues.
- R9: An overflow with interrupt enable set raises the timer's irq. After any control write, irq is low unless both done and interrupt enable are set. A control write never raises irq by itself.
- R10: bus_addr is a word index. The upper bits select the timer and the two low bits select the register: 0 control, 1 count, 2 reload, 3 vector.
- R11: Vector writes keep only bits 9:2. The vec_out slice of each timer equals its vector register.
- R12: Activity on one timer never changes the registers of the other timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Word index: timer number above two register-select bits |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| tick_en | input | 1 | Count enable shared by both timers |
| irq | output | N_TIMERS | Interrupt request per timer |
| vec_out | output | N_TIMERS*DATA_W | Vector register of each timer, timer 0 in the low slice |

## Verification
The assertions assume that bus_sel, bus_we, bus_addr and tick_en are stable and known around each rising edge. They also assume a write is a single-cycle strobe, so a write and a tick for the same timer are resolved by the write-first rule. The bench changes every input only on the falling edge and holds tick_en low during register writes. It therefore never creates a write/tick collision; the bench checks rely on this absence, while the precedence rule in R6 is left to the assertions. The overflow sweep starts each timer three counts below the wrap, so each overflow falls on a cycle that the bench can count.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    REG_CTL = 2'd0,
    REG_CNT = 2'd1,
    REG_NXT = 2'd2,
    REG_VEC = 2'd3
  } ivt_reg_e;

  localparam int BIT_RUN = 0;
  localparam int BIT_STP = 2;
  localparam int BIT_XFR = 4;
  localparam int BIT_SGL = 5;
  localparam int BIT_IE  = 6;
  localparam int BIT_DON = 7;
  localparam int BIT_ERR = 31;

  typedef struct packed {
    logic err;
    logic don;
    logic ie;
    logic stp;
    logic run;
  } ivt_ctl_t;

endpackage

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_HI = 9,
  parameter int VEC_LO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  ivt_reg_e          wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_en,
  output ivt_ctl_t          ctl_q,
  output logic [DATA_W-1:0] ctl_img,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] nxt_q,
  output logic [DATA_W-1:0] vec_q,
  output logic              irq_q,
  output logic              ovf_evt,
  output logic              ctl_wr
);

  localparam logic [DATA_W-1:0] VEC_MASK =
    ((DATA_W'(1) << (VEC_HI + 1)) - DATA_W'(1)) & ~((DATA_W'(1) << VEC_LO) - DATA_W'(1));

  // one-step increment: carry out in the top bit signals a wrap
  function automatic logic [DATA_W:0] bump(input logic [DATA_W-1:0] v);
    return {1'b0, v} + {{DATA_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic [DATA_W-1:0] image(input ivt_ctl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_RUN] = c.run;
    w[BIT_STP] = c.stp;
    w[BIT_IE]  = c.ie;
    w[BIT_DON] = c.don;
    w[BIT_ERR] = c.err;
    return w;
  endfunction

  ivt_ctl_t          ctl_n;
  logic [DATA_W-1:0] cnt_n, nxt_n, vec_n;
  logic              irq_n;
  logic              ovf;

  assign ctl_wr  = wr_en && (wr_reg == REG_CTL);
  assign ovf_evt = ovf;
  assign ctl_img = image(ctl_q);

  always_comb begin
    ctl_n = ctl_q;
    cnt_n = cnt_q;
    nxt_n = nxt_q;
    vec_n = vec_q;
    irq_n = irq_q;
    ovf   = 1'b0;
    if (wr_en) begin
      case (wr_reg)
        REG_CTL: begin
          ctl_n.don = ctl_q.don & ~wr_data[BIT_DON];
          ctl_n.err = ctl_q.err & ~wr_data[BIT_ERR];
          ctl_n.run = wr_data[BIT_RUN];
          ctl_n.stp = wr_data[BIT_STP];
          ctl_n.ie  = wr_data[BIT_IE];
          if (wr_data[BIT_XFR]) cnt_n = nxt_q;
          if (!wr_data[BIT_RUN] && wr_data[BIT_SGL]) {ovf, cnt_n} = bump(cnt_n);
        end
        REG_CNT: cnt_n = wr_data;
        REG_NXT: nxt_n = wr_data;
        default: vec_n = wr_data & VEC_MASK;
      endcase
    end else if (ctl_q.run && tick_en) begin
      {ovf, cnt_n} = bump(cnt_q);
    end
    if (ovf) begin
      if (ctl_n.don) ctl_n.err = 1'b1;
      else           ctl_n.don = 1'b1;
      if (ctl_n.stp) ctl_n.run = 1'b0;
      if (ctl_n.run || ctl_wr) cnt_n = nxt_q;
      if (ctl_n.ie) irq_n = 1'b1;
    end
    if (ctl_wr && !(ctl_n.don && ctl_n.ie)) irq_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
      nxt_q <= '0;
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      cnt_q <= cnt_n;
      nxt_q <= nxt_n;
      vec_q <= vec_n;
      irq_q <= irq_n;
    end
  end

endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
  import ivt_pkg::*;
#(
  parameter int N_TIMERS = 2,
  parameter int DATA_W   = 32,
  parameter int TSEL_W   = 1
) (
  input  logic [TSEL_W-1:0]          tsel,
  input  ivt_reg_e                   rsel,
  input  logic [N_TIMERS*DATA_W-1:0] ctl_flat,
  input  logic [N_TIMERS*DATA_W-1:0] cnt_flat,
  input  logic [N_TIMERS*DATA_W-1:0] nxt_flat,
  input  logic [N_TIMERS*DATA_W-1:0] vec_flat,
  output logic [DATA_W-1:0]          rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (tsel == TSEL_W'(i)) begin
        case (rsel)
          REG_CTL: rdata = ctl_flat[i*DATA_W +: DATA_W];
          REG_CNT: rdata = cnt_flat[i*DATA_W +: DATA_W];
          REG_NXT: rdata = nxt_flat[i*DATA_W +: DATA_W];
          default: rdata = vec_flat[i*DATA_W +: DATA_W];
        endcase
      end
    end
  end

endmodule

// File: rtl/dual_ivl_timer.sv
module dual_ivl_timer
  import ivt_pkg::*;
#(
  parameter int N_TIMERS = 2,
  parameter int DATA_W   = 32,
  parameter int VEC_HI   = 9,
  parameter int VEC_LO   = 2,
  localparam int TSEL_W  = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1,
  localparam int ADDR_W  = TSEL_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       tick_en,
  output logic [N_TIMERS-1:0]        irq,
  output logic [N_TIMERS*DATA_W-1:0] vec_out
);

  logic [TSEL_W-1:0] tsel;
  ivt_reg_e          rsel;

  assign tsel = bus_addr[ADDR_W-1:2];
  assign rsel = ivt_reg_e'(bus_addr[1:0]);

  // per-timer events and state brought out for the checker
  logic [N_TIMERS-1:0]        chwr_w, csrwr_w, ovf_w;
  logic [N_TIMERS-1:0]        run_w, stp_w, ie_w, don_w, err_w;
  logic [N_TIMERS*DATA_W-1:0] ctl_flat, cnt_flat, nxt_flat;

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    ivt_ctl_t ctl;

    assign chwr_w[i] = bus_sel && bus_we && (tsel == TSEL_W'(i));

    ivt_channel #(
      .DATA_W(DATA_W),
      .VEC_HI(VEC_HI),
      .VEC_LO(VEC_LO)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (chwr_w[i]),
      .wr_reg  (rsel),
      .wr_data (bus_wdata),
      .tick_en (tick_en),
      .ctl_q   (ctl),
      .ctl_img (ctl_flat[i*DATA_W +: DATA_W]),
      .cnt_q   (cnt_flat[i*DATA_W +: DATA_W]),
      .nxt_q   (nxt_flat[i*DATA_W +: DATA_W]),
      .vec_q   (vec_out[i*DATA_W +: DATA_W]),
      .irq_q   (irq[i]),
      .ovf_evt (ovf_w[i]),
      .ctl_wr  (csrwr_w[i])
    );

    assign run_w[i] = ctl.run;
    assign stp_w[i] = ctl.stp;
    assign ie_w[i]  = ctl.ie;
    assign don_w[i] = ctl.don;
    assign err_w[i] = ctl.err;
  end

  ivt_rdmux #(
    .N_TIMERS(N_TIMERS),
    .DATA_W  (DATA_W),
    .TSEL_W  (TSEL_W)
  ) u_rd (
    .tsel     (tsel),
    .rsel     (rsel),
    .ctl_flat (ctl_flat),
    .cnt_flat (cnt_flat),
    .nxt_flat (nxt_flat),
    .vec_flat (vec_out),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/dual_ivl_timer_chk.sv
module dual_ivl_timer_chk #(
  parameter int N_TIMERS = 2,
  parameter int DATA_W   = 32,
  parameter int VEC_HI   = 9,
  parameter int VEC_LO   = 2,
  parameter int ADDR_W   = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_sel,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [N_TIMERS-1:0]        irq,
  input logic [N_TIMERS*DATA_W-1:0] vec_out,
  input logic [N_TIMERS-1:0]        chwr_w,
  input logic [N_TIMERS-1:0]        csrwr_w,
  input logic [N_TIMERS-1:0]        ovf_w,
  input logic [N_TIMERS-1:0]        run_w,
  input logic [N_TIMERS-1:0]        stp_w,
  input logic [N_TIMERS-1:0]        ie_w,
  input logic [N_TIMERS-1:0]        don_w,
  input logic [N_TIMERS-1:0]        err_w,
  input logic [N_TIMERS*DATA_W-1:0] cnt_flat,
  input logic [N_TIMERS*DATA_W-1:0] nxt_flat
);

  localparam logic [DATA_W-1:0] KEEP_BITS =
    (DATA_W'(1) << 0) | (DATA_W'(1) << 2) | (DATA_W'(1) << 6) |
    (DATA_W'(1) << 7) | (DATA_W'(1) << (DATA_W - 1));
  localparam logic [DATA_W-1:0] VEC_KEEP =
    ((DATA_W'(1) << (VEC_HI + 1)) - DATA_W'(1)) & ~((DATA_W'(1) << VEC_LO) - DATA_W'(1));

  // R2
  ctl_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[1:0] == 2'd0) |-> ((bus_rdata & ~KEEP_BITS) == '0));

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
    // R11
    vec_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_out[i*DATA_W +: DATA_W] & ~VEC_KEEP) == '0);

    // R6
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_w[i] && !chwr_w[i]) |=> $stable(cnt_flat[i*DATA_W +: DATA_W]));

    // R7
    err_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_w[i]) |-> $past(don_w[i]));

    // R8
    stop_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_w[i] && stp_w[i] && !chwr_w[i]) |=> (!run_w[i] && cnt_flat[i*DATA_W +: DATA_W] == '0));

    // R8
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_w[i] && run_w[i] && !stp_w[i] && !chwr_w[i]) |=>
        (run_w[i] && cnt_flat[i*DATA_W +: DATA_W] == $past(nxt_flat[i*DATA_W +: DATA_W])));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(ovf_w[i]));

    // R9
    irq_after_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(csrwr_w[i]) |-> (!irq[i] || (don_w[i] && ie_w[i])));
  end

endmodule

bind dual_ivl_timer dual_ivl_timer_chk #(
  .N_TIMERS(N_TIMERS),
  .DATA_W  (DATA_W),
  .VEC_HI  (VEC_HI),
  .VEC_LO  (VEC_LO),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .vec_out   (vec_out),
  .chwr_w    (chwr_w),
  .csrwr_w   (csrwr_w),
  .ovf_w     (ovf_w),
  .run_w     (run_w),
  .stp_w     (stp_w),
  .ie_w      (ie_w),
  .don_w     (don_w),
  .err_w     (err_w),
  .cnt_flat  (cnt_flat),
  .nxt_flat  (nxt_flat)
);

// File: tb/dual_ivl_timer_bench.sv
module dual_ivl_timer_bench;

  localparam int NT = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          tick_en = 1'b0;
  logic [NT-1:0] irq;
  logic [NT*DW-1:0] vec_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  dual_ivl_timer u_dual_ivl_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq), .vec_out(vec_out)
  );

  function automatic logic [31:0] img(bit run, bit stp, bit ie, bit don, bit err);
    return (32'(run) << 0) | (32'(stp) << 2) | (32'(ie) << 6) | (32'(don) << 7) | (32'(err) << 31);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int t, input int r, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {t[0], r[1:0]}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int t, input int r, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {t[0], r[1:0]};
    #2 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] d, other;
    logic [31:0] starts [5];
    starts[0] = 32'h0; starts[1] = 32'h1; starts[2] = 32'h7FFF_FFFF;
    starts[3] = 32'hFFFF_FFFE; starts[4] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and both irq lines
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < 4; r++) begin
        rd(t, r, d);
        chk("R1 reset register", d, 32'h0);
      end
    chk("R1 reset irq", 32'(irq), 32'h0);

    // R2: stored bits and never-stored bits of the control word
    wr(1, 0, 32'hFFFF_FFFF);
    rd(1, 0, d);
    chk("R2 control readback", d, img(1, 1, 1, 0, 0));
    wr(1, 0, 32'h0);
    rd(1, 0, d);
    chk("R2 control cleared", d, 32'h0);

    // R10, R11: register map and vector mask on both timers
    for (int t = 0; t < NT; t++) begin
      wr(t, 1, 32'h1111_0000 + 32'(t));
      wr(t, 2, 32'h2222_0000 + 32'(t));
      wr(t, 3, 32'hFFFF_FFFF);
    end
    for (int t = 0; t < NT; t++) begin
      rd(t, 1, d); chk("R10 count register", d, 32'h1111_0000 + 32'(t));
      rd(t, 2, d); chk("R10 reload register", d, 32'h2222_0000 + 32'(t));
      rd(t, 3, d); chk("R11 vector masked", d, 32'h0000_03FC);
      chk("R11 vec_out slice", vec_out[t*DW +: DW], 32'h0000_03FC);
    end
    wr(0, 3, 32'h0000_0155);
    chk("R11 vector bits 9:2 only", vec_out[31:0], 32'h0000_0154);

    // R5, R12: single-step sweep around the wrap point
    for (int t = 0; t < NT; t++)
      for (int k = 0; k < 5; k++) begin
        logic wrap;
        wrap = (starts[k] == 32'hFFFF_FFFF);
        rd(1 - t, 1, other);
        wr(t, 2, 32'h100 + 32'(t));
        wr(t, 1, starts[k]);
        wr(t, 0, 32'h8000_0080 | 32'h20);
        rd(t, 1, d);
        chk("R5 single step count", d, wrap ? 32'h100 + 32'(t) : starts[k] + 32'd1);
        rd(t, 0, d);
        chk("R5 single step done flag", d, img(0, 0, 0, wrap, 0));
        rd(1 - t, 1, d);
        chk("R12 other timer count", d, other);
      end

    // R4: transfer copies reload into count, not stored
    wr(0, 0, 32'h8000_0080);
    wr(0, 2, 32'hDEAD_0000);
    wr(0, 0, 32'h10);
    rd(0, 1, d); chk("R4 transfer count", d, 32'hDEAD_0000);
    rd(0, 0, d); chk("R4 transfer not stored", d, 32'h0);

    // R6: counting only while running with tick_en
    wr(0, 1, 32'd100);
    ticks(4);
    rd(0, 1, d); chk("R6 stopped timer ignores tick", d, 32'd100);
    rd(1, 1, other);
    wr(0, 0, 32'h1);
    ticks(7);
    rd(0, 1, d); chk("R6 running count", d, 32'd107);
    repeat (3) @(negedge clk);
    rd(0, 1, d); chk("R6 no tick_en holds", d, 32'd107);
    rd(1, 1, d); chk("R12 idle timer during ticks", d, other);
    wr(0, 0, 32'h0);

    // R7, R8, R9: overflow sweep over stop and interrupt-enable settings
    for (int t = 0; t < NT; t++)
      for (int m = 0; m < 4; m++) begin
        bit stp, ie;
        stp = m[0]; ie = m[1];
        wr(t, 0, 32'h8000_0080);
        wr(t, 2, 32'hFFFF_FFFD);
        wr(t, 0, img(1, stp, ie, 0, 0) | 32'h10);
        ticks(3);
        rd(t, 1, d); chk("R8 count after first wrap", d, stp ? 32'h0 : 32'hFFFF_FFFD);
        rd(t, 0, d); chk("R7 done after first wrap", d, img(!stp, stp, ie, 1, 0));
        chk("R9 irq after wrap", 32'(irq[t]), 32'(ie));
        chk("R12 other irq quiet", 32'(irq[1-t]), 32'h0);
        ticks(3);
        rd(t, 0, d); chk("R7 error on second wrap", d, img(!stp, stp, ie, 1, !stp));
        rd(t, 1, d); chk("R8 count after second window", d, stp ? 32'h0 : 32'hFFFF_FFFD);
        // R3: writing zero to flags keeps them
        wr(t, 0, img(0, stp, ie, 0, 0));
        rd(t, 0, d); chk("R3 zero write keeps flags", d, img(0, stp, ie, 1, !stp));
        chk("R9 irq kept with done and ie", 32'(irq[t]), 32'(ie));
        if (ie) begin
          wr(t, 0, img(0, stp, 0, 0, 0));
          chk("R9 irq dropped when ie cleared", 32'(irq[t]), 32'h0);
          wr(t, 0, img(0, stp, 1, 0, 0));
          chk("R9 control write does not raise irq", 32'(irq[t]), 32'h0);
        end
        wr(t, 0, 32'h8000_0080 | img(0, stp, ie, 0, 0));
        rd(t, 0, d); chk("R3 one write clears flags", d, img(0, stp, ie, 0, 0));
        chk("R9 irq low after clear", 32'(irq[t]), 32'h0);
      end

    finish_run();
  end

endmodule